// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 262,144 words by 16 bits. The RAM exposes an active-low chip select, an active-low output gate, a read/write line whose low level is the write strobe, and one active-low enable for each 8-bit lane. The host issues one word at a time with a request/ready handshake. For each request the block produces a complete strobe sequence. Every interval of that sequence is a whole number of clock cycles, worked out when the design is built from the clock period and the RAM's nanosecond limits.

When no access is running, chip select stays high and the RAM sits in standby. On a read, the block lowers chip select and the output gate together and holds them for the read time. It then registers the word, forcing any lane the host did not enable to zero.

On a write, the read/write line goes low first while the block's own bus drivers stay off. The drivers turn on only once the RAM is guaranteed to have released the bus. The data is held until the strobe and the lane enables have returned high. After a read, the block waits out the RAM's release time before any further access can begin. This keeps the two sides from ever driving the shared bus at the same time.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and on the first cycle after it, the chip select, output gate, read/write line and both lane enables are high, ready is high, the bus is not driven and the read result is zero.
- R2: While ready is high, chip select is high. A request is taken on a rising edge where both request and ready are high. Ready is low on the following cycle and stays low until the access, including its trailing wait, is complete.
- R3: A read holds chip select and the output gate low, with read/write high, for ceil(max(55, 55, 30) ns / clock period) cycles, which is 11 cycles at 5 ns. The address does not change during that time.
- R4: The read result is registered at the end of the read. Bits 7:0 come from the lower lane, enabled by mask bit 0, and bits 15:8 come from the upper lane, enabled by mask bit 1. A lane whose mask bit is 0 reads as zero. A write leaves the read result unchanged.
- R5: During an access the lower-lane enable is the inverse of mask bit 0 and the upper-lane enable is the inverse of mask bit 1. Outside an access both enables are high.
- R6: A write holds read/write low for ceil(25 ns / clock period) plus max(ceil(25 ns / period), ceil(40 ns / period) minus the first term) cycles, which is 10 cycles at 5 ns. The output gate stays high throughout, and the address and lane enables do not change while the strobe is low.
- R7: The block drives write data only after read/write has been low for ceil(25 ns / period) cycles. It keeps driving until one cycle after the strobe rises. An enabled lane stores the host's byte, and a masked lane keeps its previous content.
- R8: After a read, chip select stays high for at least ceil(25 ns / period) + 1 cycles, which is 6 at 5 ns, before the next access. After a write, it stays high for at least 2 cycles.
- R9: The output gate and read/write are never low together. The block never drives the bus while the output gate is low, or within ceil(25 ns / period) cycles after it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Lane mask, bit 0 lower, bit 1 upper, 1 = lane used |
| rdy_o | output | 1 | High when a request can be taken |
| rdata_o | output | 16 | Registered read result |
| mem_addr_o | output | 18 | RAM address |
| mem_ce_n_o | output | 1 | RAM chip select, active low |
| mem_oe_n_o | output | 1 | RAM output gate, active low |
| mem_we_n_o | output | 1 | RAM read/write, low = write |
| mem_lb_n_o | output | 1 | Lower-lane enable, active low |
| mem_ub_n_o | output | 1 | Upper-lane enable, active low |
| mem_dq_io | inout | 16 | RAM data bus |

## Verification
The bench measures every strobe run on the memory pins, so a counter that is off by one shows up as a read gate held 10 or 12 cycles, or a strobe held 9 cycles. A read directly after a write, and a write directly after a read, exercise the idle gaps. A design that skipped the release wait after a read would start the next access after fewer than 6 high cycles of chip select. Single-lane writes over known data, followed by full and single-lane reads, expose swapped lane enables, a masked lane that gets overwritten, or a masked lane that returns stale bits instead of zero.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RD_TURN,
        ST_WR_HIZ,
        ST_WR_DATA,
        ST_WR_REC
    } seq_st_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Nanoseconds to clock cycles, rounded up, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return imax(1, (ns + clk_ns - 1) / clk_ns);
    endfunction

endpackage

// File: rtl/sram_ctl_lane.sv
module sram_ctl_lane #(
    parameter int W = 8
) (
    input  logic         drive_i,
    input  logic         en_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] pad_i,
    output logic         oe_o,
    output logic [W-1:0] out_o,
    output logic [W-1:0] rd_o
);

    // A masked lane is neither driven nor reported.
    assign oe_o  = drive_i & en_i;
    assign out_o = wdata_i;
    assign rd_o  = en_i ? pad_i : '0;

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int AW      = 18,
    parameter int DW      = 16,
    parameter int RD_CYC  = 11,
    parameter int HIZ_CYC = 5,
    parameter int DAT_CYC = 5,
    parameter int REC_CYC = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [1:0]    be_i,
    input  logic [DW-1:0] rd_lanes_i,
    output logic          rdy_o,
    output logic [DW-1:0] rdata_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_ce_n_o,
    output logic          mem_oe_n_o,
    output logic          mem_we_n_o,
    output logic [1:0]    lane_n_o,
    output logic          drive_o,
    output logic [DW-1:0] wdata_o,
    output logic [1:0]    be_o
);

    localparam int MAXC = imax(imax(RD_CYC, HIZ_CYC), imax(DAT_CYC, REC_CYC));
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        seq_st_e       st;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [1:0]    be;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          ce_n;
        logic          oe_n;
        logic          we_n;
        logic [1:0]    lane_n;
        logic          drive;
    } seq_t;

    seq_t s_d, s_q;
    logic last_cyc;

    assign last_cyc = (s_q.cnt == '0);

    always_comb begin
        s_d = s_q;
        if (!last_cyc) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    s_d.addr   = addr_i;
                    s_d.be     = be_i;
                    s_d.wdata  = wdata_i;
                    s_d.ce_n   = 1'b0;
                    s_d.lane_n = ~be_i;
                    if (we_i) begin
                        s_d.st   = ST_WR_HIZ;
                        s_d.we_n = 1'b0;
                        s_d.cnt  = CW'(HIZ_CYC - 1);
                    end else begin
                        s_d.st   = ST_RD;
                        s_d.oe_n = 1'b0;
                        s_d.cnt  = CW'(RD_CYC - 1);
                    end
                end
            end
            ST_RD: begin
                if (last_cyc) begin
                    s_d.rdata  = rd_lanes_i;
                    s_d.ce_n   = 1'b1;
                    s_d.oe_n   = 1'b1;
                    s_d.lane_n = 2'b11;
                    s_d.st     = ST_RD_TURN;
                    s_d.cnt    = CW'(HIZ_CYC - 1);
                end
            end
            ST_RD_TURN: begin
                if (last_cyc) begin
                    s_d.st = ST_IDLE;
                end
            end
            ST_WR_HIZ: begin
                if (last_cyc) begin
                    s_d.st    = ST_WR_DATA;
                    s_d.drive = 1'b1;
                    s_d.cnt   = CW'(DAT_CYC - 1);
                end
            end
            ST_WR_DATA: begin
                if (last_cyc) begin
                    s_d.st     = ST_WR_REC;
                    s_d.we_n   = 1'b1;
                    s_d.ce_n   = 1'b1;
                    s_d.lane_n = 2'b11;
                    s_d.cnt    = CW'(REC_CYC - 1);
                end
            end
            ST_WR_REC: begin
                if (last_cyc) begin
                    s_d.st    = ST_IDLE;
                    s_d.drive = 1'b0;
                end
            end
            default: begin
                s_d.st     = ST_IDLE;
                s_d.ce_n   = 1'b1;
                s_d.oe_n   = 1'b1;
                s_d.we_n   = 1'b1;
                s_d.lane_n = 2'b11;
                s_d.drive  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st     <= ST_IDLE;
            s_q.cnt    <= '0;
            s_q.addr   <= '0;
            s_q.be     <= '0;
            s_q.wdata  <= '0;
            s_q.rdata  <= '0;
            s_q.ce_n   <= 1'b1;
            s_q.oe_n   <= 1'b1;
            s_q.we_n   <= 1'b1;
            s_q.lane_n <= 2'b11;
            s_q.drive  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdy_o      = (s_q.st == ST_IDLE);
    assign rdata_o    = s_q.rdata;
    assign mem_addr_o = s_q.addr;
    assign mem_ce_n_o = s_q.ce_n;
    assign mem_oe_n_o = s_q.oe_n;
    assign mem_we_n_o = s_q.we_n;
    assign lane_n_o   = s_q.lane_n;
    assign drive_o    = s_q.drive;
    assign wdata_o    = s_q.wdata;
    assign be_o       = s_q.be;

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int AW     = 18,
    parameter int DW     = 16,
    parameter int CLK_NS = 5,
    parameter int T_RC   = 55,
    parameter int T_ACC  = 55,
    parameter int T_OE   = 30,
    parameter int T_WC   = 55,
    parameter int T_WP   = 40,
    parameter int T_DS   = 25,
    parameter int T_HZ   = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [1:0]    be_i,
    output logic          rdy_o,
    output logic [DW-1:0] rdata_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_ce_n_o,
    output logic          mem_oe_n_o,
    output logic          mem_we_n_o,
    output logic          mem_lb_n_o,
    output logic          mem_ub_n_o,
    inout  wire  [DW-1:0] mem_dq_io
);

    localparam int LW      = DW / 2;
    localparam int RD_CYC  = ns_to_cyc(imax(T_RC, imax(T_ACC, T_OE)), CLK_NS);
    localparam int HIZ_CYC = ns_to_cyc(T_HZ, CLK_NS);
    localparam int DAT_CYC = imax(ns_to_cyc(T_DS, CLK_NS),
                                  imax(1, ns_to_cyc(T_WP, CLK_NS) - HIZ_CYC));
    localparam int REC_CYC = imax(1, ns_to_cyc(T_WC, CLK_NS) - HIZ_CYC - DAT_CYC);

    logic          dq_drive;
    logic [DW-1:0] wdata_q;
    logic [1:0]    be_q;
    logic [1:0]    lane_n;
    logic [1:0]    lane_oe;
    logic [DW-1:0] lane_out;
    logic [DW-1:0] rd_lanes;

    sram_ctl_seq #(
        .AW     (AW),
        .DW     (DW),
        .RD_CYC (RD_CYC),
        .HIZ_CYC(HIZ_CYC),
        .DAT_CYC(DAT_CYC),
        .REC_CYC(REC_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .we_i      (we_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .be_i      (be_i),
        .rd_lanes_i(rd_lanes),
        .rdy_o     (rdy_o),
        .rdata_o   (rdata_o),
        .mem_addr_o(mem_addr_o),
        .mem_ce_n_o(mem_ce_n_o),
        .mem_oe_n_o(mem_oe_n_o),
        .mem_we_n_o(mem_we_n_o),
        .lane_n_o  (lane_n),
        .drive_o   (dq_drive),
        .wdata_o   (wdata_q),
        .be_o      (be_q)
    );

    assign mem_lb_n_o = lane_n[0];
    assign mem_ub_n_o = lane_n[1];

    for (genvar l = 0; l < 2; l++) begin : g_lane
        sram_ctl_lane #(.W(LW)) u_lane (
            .drive_i(dq_drive),
            .en_i   (be_q[l]),
            .wdata_i(wdata_q[l*LW +: LW]),
            .pad_i  (mem_dq_io[l*LW +: LW]),
            .oe_o   (lane_oe[l]),
            .out_o  (lane_out[l*LW +: LW]),
            .rd_o   (rd_lanes[l*LW +: LW])
        );
        assign mem_dq_io[l*LW +: LW] = lane_oe[l] ? lane_out[l*LW +: LW] : {LW{1'bz}};
    end

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int AW      = 18,
    parameter int RD_CYC  = 11,
    parameter int HIZ_CYC = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_i,
    input logic          rdy_o,
    input logic          ce_n,
    input logic          oe_n,
    input logic          we_n,
    input logic          lb_n,
    input logic          ub_n,
    input logic [AW-1:0] addr,
    input logic          drive
);

    localparam int HW = $clog2(HIZ_CYC + 1);
    localparam int RW = $clog2(RD_CYC + 1);

    logic [HW-1:0] since_oe;
    logic [HW-1:0] we_low;
    logic [RW-1:0] oe_low;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_oe <= HW'(HIZ_CYC);
            we_low   <= '0;
            oe_low   <= '0;
        end else begin
            if (!oe_n)                        since_oe <= '0;
            else if (since_oe < HW'(HIZ_CYC)) since_oe <= since_oe + 1'b1;
            if (we_n)                         we_low <= '0;
            else if (we_low < HW'(HIZ_CYC))   we_low <= we_low + 1'b1;
            if (oe_n)                         oe_low <= '0;
            else if (oe_low < RW'(RD_CYC))    oe_low <= oe_low + 1'b1;
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |-> (ce_n && oe_n && we_n && lb_n && ub_n && !drive));

    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && rdy_o) |=> !rdy_o);

    a_r3_read_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n) |-> (oe_low == RW'(RD_CYC)));

    a_r6_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> ($stable(addr) && $stable(lb_n) && $stable(ub_n)));

    a_r7_drive_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && !we_n) |-> (we_low == HW'(HIZ_CYC)));

    a_r9_no_drive_near_read: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> (oe_n && since_oe == HW'(HIZ_CYC)));

    a_r9_gate_strobe_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

endmodule

bind sram_ctl sram_ctl_chk #(
    .AW     (AW),
    .RD_CYC (RD_CYC),
    .HIZ_CYC(HIZ_CYC)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .req_i(req_i),
    .rdy_o(rdy_o),
    .ce_n (mem_ce_n_o),
    .oe_n (mem_oe_n_o),
    .we_n (mem_we_n_o),
    .lb_n (mem_lb_n_o),
    .ub_n (mem_ub_n_o),
    .addr (mem_addr_o),
    .drive(dq_drive)
);

// File: tb/sram_ctl_tb.sv
module sram_ctl_tb;

    localparam int RD_LEN  = 11;
    localparam int WE_LEN  = 10;
    localparam int GAP_RD  = 6;
    localparam int GAP_WR  = 2;

    typedef struct packed {
        logic        wr;
        logic [17:0] a;
        logic [15:0] d;
        logic [1:0]  be;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 18'h30001, 16'hA55A, 2'b11, 16'h0000},
        '{1'b1, 18'h00002, 16'h1234, 2'b11, 16'h0000},
        '{1'b0, 18'h30001, 16'h0000, 2'b11, 16'hA55A},
        '{1'b1, 18'h00002, 16'hFFEE, 2'b01, 16'h0000},
        '{1'b0, 18'h00002, 16'h0000, 2'b11, 16'h12EE},
        '{1'b1, 18'h00002, 16'h7700, 2'b10, 16'h0000},
        '{1'b0, 18'h00002, 16'h0000, 2'b10, 16'h7700},
        '{1'b0, 18'h00002, 16'h0000, 2'b01, 16'h00EE},
        '{1'b0, 18'h30001, 16'h0000, 2'b00, 16'h0000},
        '{1'b1, 18'h2000F, 16'hBEEF, 2'b11, 16'h0000},
        '{1'b0, 18'h2000F, 16'h0000, 2'b11, 16'hBEEF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [17:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  be = '0;
    logic        rdy;
    logic [15:0] rdata;
    logic [17:0] m_addr;
    logic        ce_n, oe_n, we_n, lb_n, ub_n;
    wire  [15:0] dq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] mem [16];

    always #2.5 clk = ~clk;

    sram_ctl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .we_i      (we),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .be_i      (be),
        .rdy_o     (rdy),
        .rdata_o   (rdata),
        .mem_addr_o(m_addr),
        .mem_ce_n_o(ce_n),
        .mem_oe_n_o(oe_n),
        .mem_we_n_o(we_n),
        .mem_lb_n_o(lb_n),
        .mem_ub_n_o(ub_n),
        .mem_dq_io (dq)
    );

    // Memory model: drives a lane only in read mode with that lane enabled.
    assign dq[7:0]  = (!ce_n && we_n && !oe_n && !lb_n) ? mem[m_addr[3:0]][7:0]  : 8'hzz;
    assign dq[15:8] = (!ce_n && we_n && !oe_n && !ub_n) ? mem[m_addr[3:0]][15:8] : 8'hzz;

    task automatic check(input bit ok, input string req_tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req_tag, act, exp, $time);
        end
    endtask

    // Pin monitor and memory write port, sampled at the falling edge.
    logic [17:0] cur_a = '0;
    logic [1:0]  cur_be = '0;
    int  oe_run = 0, we_run = 0, ce_hi_run = 100;
    bit  last_rd = 0;
    logic p_oe = 1'b1, p_we = 1'b1, p_ce = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!ce_n && !we_n) begin
                if (!lb_n) mem[m_addr[3:0]][7:0]  = dq[7:0];
                if (!ub_n) mem[m_addr[3:0]][15:8] = dq[15:8];
            end
            if (rdy && !ce_n) check(0, "R2 standby while ready", {31'd0, ce_n}, 32'd1);
            if (!oe_n && !we_n) check(0, "R9 gate and strobe together", 32'd0, 32'd1);
            if (!oe_n) begin
                oe_run++;
                if (!we_n) check(0, "R3 read/write high in read", {31'd0, we_n}, 32'd1);
            end else if (!p_oe) begin
                check(oe_run == RD_LEN, "R3 read gate length", oe_run, RD_LEN);
                oe_run = 0;
            end
            if (!we_n) begin
                we_run++;
                if (m_addr != cur_a || {ub_n, lb_n} != ~cur_be)
                    check(0, "R6 address/lanes steady in strobe", {12'd0, m_addr, ub_n, lb_n},
                          {12'd0, cur_a, ~cur_be});
            end else if (!p_we) begin
                check(we_run == WE_LEN, "R6 strobe length", we_run, WE_LEN);
                we_run = 0;
            end
            if (ce_n) begin
                ce_hi_run++;
                if ({ub_n, lb_n} != 2'b11) check(0, "R5 lanes high outside access",
                                                 {30'd0, ub_n, lb_n}, 32'd3);
            end else if (p_ce) begin
                check(ce_hi_run >= (last_rd ? GAP_RD : GAP_WR), "R8 gap before access",
                      ce_hi_run, last_rd ? GAP_RD : GAP_WR);
                check({ub_n, lb_n} == ~cur_be, "R5 lane enables", {30'd0, ub_n, lb_n},
                      {30'd0, ~cur_be});
                check(m_addr == cur_a, "R3 address presented", m_addr, cur_a);
                last_rd = we_n;
                ce_hi_run = 0;
            end
            p_oe = oe_n; p_we = we_n; p_ce = ce_n;
        end
    end

    task automatic access(input logic w, input logic [17:0] a, input logic [15:0] d,
                          input logic [1:0] b);
        @(negedge clk);
        while (!rdy) @(negedge clk);
        cur_a = a; cur_be = b;
        req = 1'b1; we = w; addr = a; wdata = d; be = b;
        @(negedge clk);
        req = 1'b0;
        check(rdy == 1'b0, "R2 ready low after accept", {31'd0, rdy}, 32'd0);
        while (!rdy) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        check(ce_n && oe_n && we_n && lb_n && ub_n && rdy && rdata == 16'h0,
              "R1 reset state", {11'd0, ce_n, oe_n, we_n, lb_n, ub_n, rdy, rdata}, {11'd0, 6'h3F, 16'h0});
        rst_n = 1'b1;
        @(negedge clk);
        check(ce_n && oe_n && we_n && lb_n && ub_n && rdy && rdata == 16'h0,
              "R1 first cycle after reset", {11'd0, ce_n, oe_n, we_n, lb_n, ub_n, rdy, rdata}, {11'd0, 6'h3F, 16'h0});

        for (int v = 0; v < NV; v++) begin
            access(VEC[v].wr, VEC[v].a, VEC[v].d, VEC[v].be);
            if (!VEC[v].wr)
                check(rdata == VEC[v].exp, "R4/R7 read result", {16'd0, rdata}, {16'd0, VEC[v].exp});
        end

        // R4: a write must not disturb the last read result.
        access(1'b1, 18'h00005, 16'h5A5A, 2'b11);
        check(rdata == 16'hBEEF, "R4 result kept across write", {16'd0, rdata}, 32'h0000BEEF);
        // R7: fully masked write leaves the word untouched.
        access(1'b1, 18'h00005, 16'h0F0F, 2'b00);
        access(1'b0, 18'h00005, 16'h0000, 2'b11);
        check(rdata == 16'h5A5A, "R7 masked write keeps word", {16'd0, rdata}, 32'h00005A5A);
        // R8: back-to-back reads still wait out the release time.
        access(1'b0, 18'h30001, 16'h0000, 2'b01);
        check(rdata == 16'h005A, "R4 lower lane only", {16'd0, rdata}, 32'h0000005A);
        access(1'b0, 18'h30001, 16'h0000, 2'b10);
        check(rdata == 16'hA500, "R4 upper lane only", {16'd0, rdata}, 32'h0000A500);
        repeat (4) @(negedge clk);
        check(ce_n && rdy, "R2 idle after sequence", {30'd0, ce_n, rdy}, 32'd3);

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule